// File: doc/BRIEF.md
# Set-Associative Cache Lookup Unit

This block is the tag-compare and hit-detection stage of a cache with 128 sets and up to eight ways. Each line holds four 64-bit doublewords, which is 32 bytes. A lookup takes two addresses. The set index and the doubleword select come from the untranslated (virtual) address. The tag reference comes from the translated (physical) address, which an external translation unit supplies. Every present way of the selected set is compared in parallel. The block returns a registered hit flag, a one-hot vector naming the hitting way, and the selected doubleword.

Around the lookup, three other inputs change the stored state. A fill port writes a tag and a whole line into a chosen way. A global invalidate clears every valid bit. A lookup marked as a write updates the hit doubleword, but only when the externally supplied write-permission bit is set. Choosing the victim way and sequencing bus refills are done outside the block. Both arrive here as inputs.

Top module: `cache_lookup`

## Requirements
- R1: Bit 0 is the least significant bit. The set index is `lk_vaddr[11:5]`, the doubleword select is `lk_vaddr[4:3]`, and the tag is `lk_paddr[31:12]`. Bits `lk_vaddr[2:0]` are a byte offset and have no effect on the result.
- R2: A request present at a rising clock edge produces `rsp_valid`=1 and its `rsp_hit`, `rsp_hit_way` and `rsp_data` from that same edge. A cycle with no request gives `rsp_valid`=0 and `rsp_hit`=0.
- R3: A way hits only when its valid bit is set and its stored tag equals the tag reference. At most one bit of `rsp_hit_way` is ever set.
- R4: `rsp_hit` is the OR of the per-way hits. Bit w of `rsp_hit_way` marks way w.
- R5: A read hit returns the selected doubleword on `rsp_data`. A miss, and any write lookup, returns zero data. A miss also returns a zero `rsp_hit_way`.
- R6: A fill writes the tag from `fill_paddr[31:12]` and the line `fill_line` into way `fill_way` at set `fill_vaddr[11:5]`, and marks that entry valid. Doubleword d sits at `fill_line[64*d+63:64*d]`.
- R7: When a fill targets the same set as a lookup in the same cycle, the fill goes ahead and the lookup reports a miss.
- R8: A write hit with `lk_wperm`=1 replaces the selected doubleword with `lk_wdata`. A write with `lk_wperm`=0, and a write miss, leave the stored data unchanged.
- R9: `inv_all` clears every valid bit, and a lookup in the same cycle misses. A fill in the same cycle as `inv_all` leaves its own entry valid.
- R10: `NUM_WAYS` may be set from 2 to 8. Only the present ways take part in the compare and the hit OR, and `rsp_hit_way` is `NUM_WAYS` bits wide.
- R11: A synchronous active-high `rst` clears all valid bits and all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write |
| lk_wperm | input | 1 | Write permission from translation |
| lk_vaddr | input | 32 | Untranslated address: index and doubleword select |
| lk_paddr | input | 32 | Translated address: tag reference |
| lk_wdata | input | 64 | Write data for a permitted write hit |
| fill_en | input | 1 | Line fill strobe |
| fill_way | input | clog2(NUM_WAYS) | Way to fill |
| fill_vaddr | input | 32 | Untranslated fill address (set index) |
| fill_paddr | input | 32 | Translated fill address (tag) |
| fill_line | input | 256 | Four doublewords of the line |
| inv_all | input | 1 | Clear all valid bits |
| rsp_valid | output | 1 | Response for a request sampled at the last edge |
| rsp_hit | output | 1 | Lookup hit |
| rsp_hit_way | output | NUM_WAYS | One-hot hitting way |
| rsp_data | output | 64 | Selected doubleword on a read hit, else zero |

## Verification
Reads sweep all four doubleword positions and vary the byte offset. This shows that the right field picks the data and that the low address bits are ignored. Filling all eight ways of one set with distinct tags, then reading each one, tells a correct one-hot way vector from a wrong way or a merged result. A tag mismatch and a set mismatch are each tested on their own. Collisions with a fill on the same set and on a neighbouring set separate the priority rule from a general stall. Writes with and without permission, and a write miss, are each followed by a read that shows whether the data changed.

// File: rtl/cache_lu_pkg.sv
package cache_lu_pkg;

    localparam int ADDR_W     = 32;
    localparam int TAG_W      = 20;
    localparam int SET_W      = 7;
    localparam int DWSEL_W    = 2;
    localparam int DW_W       = 64;
    localparam int OFF_W      = 3;

    localparam int NUM_SETS    = 1 << SET_W;
    localparam int DW_PER_LINE = 1 << DWSEL_W;
    localparam int LINE_W      = DW_W * DW_PER_LINE;

    localparam int DW_LSB  = OFF_W;
    localparam int SET_LSB = DW_LSB + DWSEL_W;
    localparam int TAG_LSB = ADDR_W - TAG_W;

    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [SET_W-1:0]   set_t;
    typedef logic [DWSEL_W-1:0] dwsel_t;
    typedef logic [DW_W-1:0]    dword_t;
    typedef logic [LINE_W-1:0]  line_t;

    typedef struct packed {
        tag_t   tag;
        set_t   set;
        dwsel_t dw;
    } lookup_key_t;

    function automatic dword_t pick_dw(line_t line, dwsel_t dw);
        return line[int'(dw)*DW_W +: DW_W];
    endfunction

endpackage

// File: rtl/cl_way.sv
module cl_way
    import cache_lu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   inv_all,
    input  set_t   look_set,
    input  tag_t   look_tag,
    output logic   way_hit,
    output line_t  way_line,
    input  logic   fill_en,
    input  set_t   fill_set,
    input  tag_t   fill_tag,
    input  line_t  fill_line,
    input  logic   upd_en,
    input  set_t   upd_set,
    input  dwsel_t upd_dw,
    input  dword_t upd_data
);

    logic [NUM_SETS-1:0] vld;
    tag_t  tag_mem [NUM_SETS];
    line_t dat_mem [NUM_SETS];

    // valid bits: invalidate first, a same-cycle fill re-validates its entry
    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            if (inv_all) vld <= '0;
            if (fill_en) vld[fill_set] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_mem[fill_set] <= fill_tag;
            dat_mem[fill_set] <= fill_line;
        end
        if (upd_en) begin
            dat_mem[upd_set][int'(upd_dw)*DW_W +: DW_W] <= upd_data;
        end
    end

    always_comb begin
        way_hit  = vld[look_set] && (tag_mem[look_set] == look_tag);
        way_line = dat_mem[look_set];
    end

    // R9: invalidate without a fill leaves no valid entry
    a_r9_inv_clears: assert property (@(posedge clk) disable iff (rst)
        inv_all && !fill_en |=> vld == '0);

    // R6: a filled entry is valid on the following cycle
    a_r6_fill_valid: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> vld[$past(fill_set)]);

    // R8: an update never lands on the entry being filled
    a_r8_no_fill_clash: assert property (@(posedge clk) disable iff (rst)
        !(upd_en && fill_en && (upd_set == fill_set)));

endmodule

// File: rtl/cl_hit_merge.sv
module cl_hit_merge
    import cache_lu_pkg::*;
#(
    parameter int NUM_WAYS = 8
) (
    input  logic [NUM_WAYS-1:0] hits,
    input  line_t               lines [NUM_WAYS],
    output logic                any_hit,
    output line_t               sel_line
);

    // AND-OR select: with a one-hot hit vector exactly one line passes
    always_comb begin
        sel_line = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (hits[w]) sel_line = sel_line | lines[w];
        end
        any_hit = |hits;
    end

endmodule

// File: rtl/cache_lookup.sv
module cache_lookup
    import cache_lu_pkg::*;
#(
    parameter  int NUM_WAYS = 8,
    localparam int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_req,
    input  logic                lk_write,
    input  logic                lk_wperm,
    input  logic [31:0]         lk_vaddr,
    input  logic [31:0]         lk_paddr,
    input  logic [63:0]         lk_wdata,
    input  logic                fill_en,
    input  logic [WAY_W-1:0]    fill_way,
    input  logic [31:0]         fill_vaddr,
    input  logic [31:0]         fill_paddr,
    input  logic [255:0]        fill_line,
    input  logic                inv_all,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [NUM_WAYS-1:0] rsp_hit_way,
    output logic [63:0]         rsp_data
);

    lookup_key_t key;
    set_t        f_set;
    tag_t        f_tag;
    logic        collide;
    logic        blocked;
    logic        any_hit;
    logic        eff_hit;
    line_t       sel_line;
    logic [NUM_WAYS-1:0] raw_hit;
    line_t       way_lines [NUM_WAYS];

    logic unused_addr_bits;
    assign unused_addr_bits = ^{lk_vaddr[ADDR_W-1:SET_LSB+SET_W], lk_vaddr[OFF_W-1:0],
                                lk_paddr[TAG_LSB-1:0],
                                fill_vaddr[ADDR_W-1:SET_LSB+SET_W], fill_vaddr[SET_LSB-1:0],
                                fill_paddr[TAG_LSB-1:0]};

    always_comb begin
        key.tag = lk_paddr[TAG_LSB +: TAG_W];
        key.set = lk_vaddr[SET_LSB +: SET_W];
        key.dw  = lk_vaddr[DW_LSB +: DWSEL_W];
        f_set   = fill_vaddr[SET_LSB +: SET_W];
        f_tag   = fill_paddr[TAG_LSB +: TAG_W];
        collide = fill_en && (f_set == key.set);
        blocked = collide || inv_all;
        eff_hit = lk_req && any_hit && !blocked;
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic fill_here;
        logic upd_here;
        assign fill_here = fill_en && (fill_way == WAY_W'(w));
        assign upd_here  = lk_req && lk_write && lk_wperm && !blocked && raw_hit[w];

        cl_way u_way (
            .clk       (clk),
            .rst       (rst),
            .inv_all   (inv_all),
            .look_set  (key.set),
            .look_tag  (key.tag),
            .way_hit   (raw_hit[w]),
            .way_line  (way_lines[w]),
            .fill_en   (fill_here),
            .fill_set  (f_set),
            .fill_tag  (f_tag),
            .fill_line (fill_line),
            .upd_en    (upd_here),
            .upd_set   (key.set),
            .upd_dw    (key.dw),
            .upd_data  (lk_wdata)
        );
    end

    cl_hit_merge #(.NUM_WAYS(NUM_WAYS)) u_merge (
        .hits     (raw_hit),
        .lines    (way_lines),
        .any_hit  (any_hit),
        .sel_line (sel_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_hit_way <= '0;
            rsp_data    <= '0;
        end else begin
            rsp_valid   <= lk_req;
            rsp_hit     <= eff_hit;
            rsp_hit_way <= eff_hit ? raw_hit : '0;
            rsp_data    <= (eff_hit && !lk_write) ? pick_dw(sel_line, key.dw) : '0;
        end
    end

    // R2: no request, no response
    a_r2_idle: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rsp_valid && !rsp_hit);

    // R3: at most one way reports a hit
    a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_hit_way));

    // R4: hit flag agrees with the way vector
    a_r4_hit_or: assert property (@(posedge clk) disable iff (rst)
        rsp_hit == (rsp_hit_way != '0));

    // R5: a miss returns zero data
    a_r5_miss_zero: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> rsp_data == '0);

    // R7: a fill on the looked-up set forces a miss
    a_r7_fill_wins: assert property (@(posedge clk) disable iff (rst)
        lk_req && fill_en && (fill_vaddr[SET_LSB +: SET_W] == lk_vaddr[SET_LSB +: SET_W])
        |=> !rsp_hit);

    // R9: a lookup during invalidate misses
    a_r9_inv_miss: assert property (@(posedge clk) disable iff (rst)
        lk_req && inv_all |=> !rsp_hit);

endmodule

// File: tb/sim_cache_lookup.sv
module sim_cache_lookup;

    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         lk_req, lk_write, lk_wperm;
    logic [31:0]  lk_vaddr, lk_paddr;
    logic [63:0]  lk_wdata;
    logic         fill_en;
    logic [2:0]   fill_way;
    logic [31:0]  fill_vaddr, fill_paddr;
    logic [255:0] fill_line;
    logic         inv_all;
    logic         rsp_valid, rsp_hit;
    logic [7:0]   rsp_hit_way;
    logic [63:0]  rsp_data;

    logic         fill_en1;
    logic [0:0]   fill_way1;
    logic         rsp_valid1, rsp_hit1;
    logic [1:0]   rsp_hit_way1;
    logic [63:0]  rsp_data1;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    cache_lookup #(.NUM_WAYS(8)) u0 (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_write(lk_write), .lk_wperm(lk_wperm),
        .lk_vaddr(lk_vaddr), .lk_paddr(lk_paddr), .lk_wdata(lk_wdata),
        .fill_en(fill_en), .fill_way(fill_way), .fill_vaddr(fill_vaddr),
        .fill_paddr(fill_paddr), .fill_line(fill_line), .inv_all(inv_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hit_way(rsp_hit_way),
        .rsp_data(rsp_data)
    );

    cache_lookup #(.NUM_WAYS(2)) u1 (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_write(lk_write), .lk_wperm(lk_wperm),
        .lk_vaddr(lk_vaddr), .lk_paddr(lk_paddr), .lk_wdata(lk_wdata),
        .fill_en(fill_en1), .fill_way(fill_way1), .fill_vaddr(fill_vaddr),
        .fill_paddr(fill_paddr), .fill_line(fill_line), .inv_all(inv_all),
        .rsp_valid(rsp_valid1), .rsp_hit(rsp_hit1), .rsp_hit_way(rsp_hit_way1),
        .rsp_data(rsp_data1)
    );

    function automatic logic [63:0] pat(int seed, int d);
        return {16'hC0DE, seed[15:0], 16'h0000, 8'h00, d[7:0]};
    endfunction

    function automatic logic [255:0] mkline(int seed);
        return {pat(seed, 3), pat(seed, 2), pat(seed, 1), pat(seed, 0)};
    endfunction

    function automatic logic [31:0] va(int set, int dw, int off);
        return {20'h0, set[6:0], dw[1:0], off[2:0]};
    endfunction

    function automatic logic [31:0] pa(logic [19:0] tag);
        return {tag, 12'h000};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        lk_req = 0; lk_write = 0; lk_wperm = 0; lk_vaddr = '0; lk_paddr = '0;
        lk_wdata = '0; fill_en = 0; fill_way = '0; fill_vaddr = '0; fill_paddr = '0;
        fill_line = '0; inv_all = 0; fill_en1 = 0; fill_way1 = '0;
    endtask

    task automatic set_fill(int way, int set, logic [19:0] tag, int seed);
        fill_en = 1; fill_way = way[2:0]; fill_vaddr = va(set, 0, 0);
        fill_paddr = pa(tag); fill_line = mkline(seed);
    endtask

    task automatic set_look(int set, int dw, int off, logic [19:0] tag);
        lk_req = 1; lk_vaddr = va(set, dw, off); lk_paddr = pa(tag);
    endtask

    task automatic fill(int way, int set, logic [19:0] tag, int seed);
        set_fill(way, set, tag, seed);
        step();
        clear_in();
    endtask

    // one read lookup; outputs checked by caller right after
    task automatic read(int set, int dw, int off, logic [19:0] tag);
        set_look(set, dw, off, tag);
        step();
        clear_in();
    endtask

    task automatic write(int set, int dw, logic [19:0] tag, logic perm, logic [63:0] d);
        set_look(set, dw, 0, tag);
        lk_write = 1; lk_wperm = perm; lk_wdata = d;
        step();
        clear_in();
    endtask

    task automatic t_reset();
        chk("R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R11 rsp_hit after reset", 64'(rsp_hit), 64'd0);
        read(10, 0, 0, 20'h12345);
        chk("R2 rsp_valid on request", 64'(rsp_valid), 64'd1);
        chk("R11 empty cache misses", 64'(rsp_hit), 64'd0);
        step();
        chk("R2 rsp_valid idle", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_fill_read();
        fill(3, 10, 20'h12345, 1);
        for (int d = 0; d < 4; d++) begin
            read(10, d, d * 2, 20'h12345);
            chk("R6 fill then hit", 64'(rsp_hit), 64'd1);
            chk("R4 hit way 3", 64'(rsp_hit_way), 64'h08);
            chk("R5 R1 doubleword data", rsp_data, pat(1, d));
        end
        read(10, 1, 7, 20'h12345);
        chk("R1 byte offset ignored", rsp_data, pat(1, 1));
        read(10, 0, 0, 20'h12346);
        chk("R3 tag mismatch miss", 64'(rsp_hit), 64'd0);
        chk("R5 miss way zero", 64'(rsp_hit_way), 64'd0);
        chk("R5 miss data zero", rsp_data, 64'd0);
        read(11, 0, 0, 20'h12345);
        chk("R1 other set misses", 64'(rsp_hit), 64'd0);
    endtask

    task automatic t_all_ways();
        for (int w = 0; w < 8; w++) fill(w, 20, 20'hA0000 + 20'(w), 100 + w);
        for (int w = 0; w < 8; w++) begin
            read(20, 2, 0, 20'hA0000 + 20'(w));
            chk("R3 R4 one-hot way", 64'(rsp_hit_way), 64'(8'(1) << w));
            chk("R5 way data", rsp_data, pat(100 + w, 2));
        end
    endtask

    task automatic t_write();
        write(10, 2, 20'h12345, 1'b1, 64'hFEED_0000_1111_2222);
        chk("R8 write hit flag", 64'(rsp_hit), 64'd1);
        chk("R5 write returns zero", rsp_data, 64'd0);
        read(10, 2, 0, 20'h12345);
        chk("R8 permitted write stored", rsp_data, 64'hFEED_0000_1111_2222);
        read(10, 1, 0, 20'h12345);
        chk("R8 neighbour doubleword intact", rsp_data, pat(1, 1));
        write(10, 2, 20'h12345, 1'b0, 64'hBAD0_BAD0_BAD0_BAD0);
        read(10, 2, 0, 20'h12345);
        chk("R8 unpermitted write ignored", rsp_data, 64'hFEED_0000_1111_2222);
        write(10, 2, 20'h54321, 1'b1, 64'hBAD1_BAD1_BAD1_BAD1);
        chk("R8 write miss flag", 64'(rsp_hit), 64'd0);
        read(10, 2, 0, 20'h12345);
        chk("R8 write miss ignored", rsp_data, 64'hFEED_0000_1111_2222);
    endtask

    task automatic t_collide();
        set_fill(5, 10, 20'h77777, 7);
        set_look(10, 0, 0, 20'h12345);
        step();
        clear_in();
        chk("R7 same-set fill forces miss", 64'(rsp_hit), 64'd0);
        read(10, 3, 0, 20'h77777);
        chk("R7 fill still done", 64'(rsp_hit_way), 64'h20);
        chk("R7 filled data", rsp_data, pat(7, 3));
        read(10, 0, 0, 20'h12345);
        chk("R7 resident line kept", 64'(rsp_hit_way), 64'h08);
        set_fill(6, 11, 20'h33333, 8);
        set_look(10, 0, 0, 20'h12345);
        step();
        clear_in();
        chk("R7 other-set fill no effect", 64'(rsp_hit), 64'd1);
    endtask

    task automatic t_inv();
        inv_all = 1;
        set_look(20, 0, 0, 20'hA0002);
        set_fill(2, 30, 20'h0ABCD, 9);
        step();
        clear_in();
        chk("R9 lookup during invalidate misses", 64'(rsp_hit), 64'd0);
        read(10, 0, 0, 20'h12345);
        chk("R9 old line invalid", 64'(rsp_hit), 64'd0);
        read(20, 0, 0, 20'hA0002);
        chk("R9 other set invalid", 64'(rsp_hit), 64'd0);
        read(30, 1, 0, 20'h0ABCD);
        chk("R9 concurrent fill valid", 64'(rsp_hit_way), 64'h04);
        chk("R9 concurrent fill data", rsp_data, pat(9, 1));
    endtask

    task automatic t_two_way();
        fill_en1 = 1; fill_way1 = 1'b0; fill_vaddr = va(40, 0, 0);
        fill_paddr = pa(20'h11111); fill_line = mkline(41);
        step();
        clear_in();
        fill_en1 = 1; fill_way1 = 1'b1; fill_vaddr = va(40, 0, 0);
        fill_paddr = pa(20'h22222); fill_line = mkline(42);
        step();
        clear_in();
        read(40, 0, 0, 20'h11111);
        chk("R10 two-way hit way 0", 64'(rsp_hit_way1), 64'h1);
        chk("R10 two-way data 0", rsp_data1, pat(41, 0));
        read(40, 3, 0, 20'h22222);
        chk("R10 two-way hit way 1", 64'(rsp_hit_way1), 64'h2);
        chk("R10 two-way data 1", rsp_data1, pat(42, 3));
        read(40, 0, 0, 20'h33333);
        chk("R10 two-way miss", 64'(rsp_hit1), 64'd0);
    endtask

    task automatic t_reset_clears();
        rst = 1;
        step();
        rst = 0;
        step();
        read(30, 1, 0, 20'h0ABCD);
        chk("R11 reset clears valid", 64'(rsp_hit), 64'd0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_in();
        rst = 1;
        @(negedge clk);
        step();
        step();
        rst = 0;
        step();
        t_reset();
        t_fill_read();
        t_all_ways();
        t_write();
        t_collide();
        t_inv();
        t_two_way();
        t_reset_clears();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule